// File: doc/BRIEF.md
# Stack Push/Pull Sequencer

This block is the multi-cycle controller for the stack instructions of an 8-bit microcontroller core. It handles six single-byte instructions: push accumulator, push status, pull accumulator, pull status, return from interrupt and return from subroutine. The decoder upstream hands it an opcode together with a one-cycle `start` pulse. The block then runs the instruction over a fixed number of cycles and pulses `done` in the last of them. It owns the 8-bit stack pointer. It drives a synchronous memory port whose read data arrives one cycle after the address. Fetch, operand addressing, interrupt entry and arithmetic all live elsewhere.

The surrounding datapath supplies the current accumulator and status values on `acc_in` and `ps_in`. It accepts new values from the block through write strobes: `acc_we`, `ps_we` and `pc_we`. Each strobe is a single-cycle pulse, and the matching data port is valid during that cycle.

The stack address is always the fixed page byte `STACK_PAGE` joined to the stack pointer. A push stores at the current pointer and then steps the pointer down. A pull steps the pointer up and then loads. Each read is issued one cycle after the previous one, so the three reads of return from interrupt overlap with their one-cycle latency and fit inside the cycle budget.

Controller states:
- `S_IDLE`: waits for a start pulse.
- `S_PUSH_WR`: writes the byte and decrements the pointer.
- `S_PUSH_HOLD`: a spare cycle of the push.
- `S_PRE_INC`: the first pointer increment of any pull.
- `S_READ`: issues addresses and captures returning bytes, one of each per cycle as needed.
- `S_PAD`: a spare cycle of return from subroutine.
- `S_FINISH`: raises `done`.

Transitions:
- `S_IDLE` to `S_PUSH_WR` on a push opcode.
- `S_IDLE` to `S_PRE_INC` on a pull or return opcode.
- `S_PUSH_WR` to `S_PUSH_HOLD` to `S_FINISH`.
- `S_PRE_INC` to `S_READ`.
- `S_READ` stays until the last byte is captured, then goes to `S_PAD` for return from subroutine and to `S_FINISH` otherwise.
- `S_PAD` to `S_FINISH`.
- `S_FINISH` to `S_IDLE`.

Top module: `stack_seq`

## Requirements
- R1: After reset, `sp` is FFh and `busy`, `done`, `mem_we`, `acc_we`, `ps_we` and `pc_we` are all low.
- R2: `mem_addr` always equals `{STACK_PAGE, sp}`, for writes and for reads.
- R3: Opcode 48h writes `acc_in` at the current stack address, then decrements `sp`. `done` is high in cycle 3, counting the cycle after the start edge as cycle 1.
- R4: Opcode 08h writes `ps_in` at the current stack address, then decrements `sp`. `done` is high in cycle 3.
- R5: Opcode 68h increments `sp`, then pulses `acc_we` with the byte stored at the new address on `acc_out`. `done` is high in cycle 4.
- R6: Opcode 28h increments `sp`, then pulses `ps_we` with the byte stored at the new address on `ps_out`. `done` is high in cycle 4.
- R7: Opcode 40h performs three pulls. Each is preceded by an increment. They go in this order: the status byte, the PC low byte, then the PC high byte. `pc_out` equals exactly {high, low}, `sp` ends 3 above its start, and `done` is high in cycle 6.
- R8: Opcode 60h performs two pulls, the PC low byte and then the PC high byte. `pc_out` equals {high, low} + 1, modulo 2^16. `sp` ends 2 above its start, and `done` is high in cycle 6.
- R9: `sp` wraps modulo 256 in both directions.
- R10: `done` is a single-cycle pulse in the last cycle of the instruction. `busy` is high from cycle 1 through that last cycle and low afterwards.
- R11: A start pulse that arrives while `busy` is high is ignored. It causes no memory write, no pointer change and no extra `done`.
- R12: A start pulse with an opcode outside 48h, 08h, 68h, 28h, 40h and 60h is ignored. `busy` and `done` stay low, and `sp` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to run `opcode` |
| opcode | input | 8 | Decoded instruction byte |
| acc_in | input | 8 | Current accumulator value |
| ps_in | input | 8 | Current status register value |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| mem_addr | output | 16 | Stack memory address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable |
| acc_out | output | 8 | New accumulator value |
| acc_we | output | 1 | Accumulator load strobe |
| ps_out | output | 8 | New status value |
| ps_we | output | 1 | Status load strobe |
| pc_out | output | 16 | New program counter |
| pc_we | output | 1 | Program counter load strobe |
| sp | output | 8 | Stack pointer |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Last cycle of the instruction |

## Verification
The bench builds the block with `STACK_PAGE` set to 3Ch, so a wrong or missing page byte shows up on every access. The stack pointer is left at its reset value of FFh, so that 256 consecutive pushes and then 256 pulls sweep every pointer value and cross the 00h/FFh boundary in both directions. The return instructions are run from shifted pointer positions so that their multi-byte pulls straddle the wrap. They also use a low byte of FFh, which exposes the carry of the subroutine-return increment into the high byte.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

    localparam int BYTE_W = 8;
    localparam int PC_W   = 2 * BYTE_W;
    localparam int CNT_W  = 2;

    localparam logic [BYTE_W-1:0] OP_PUSH_A  = 8'h48;
    localparam logic [BYTE_W-1:0] OP_PUSH_PS = 8'h08;
    localparam logic [BYTE_W-1:0] OP_PULL_A  = 8'h68;
    localparam logic [BYTE_W-1:0] OP_PULL_PS = 8'h28;
    localparam logic [BYTE_W-1:0] OP_RET_INT = 8'h40;
    localparam logic [BYTE_W-1:0] OP_RET_SUB = 8'h60;

    typedef enum logic [2:0] {
        K_NONE,
        K_PUSH_A,
        K_PUSH_PS,
        K_PULL_A,
        K_PULL_PS,
        K_RET_INT,
        K_RET_SUB
    } kind_e;

    typedef enum logic [1:0] {
        D_ACC,
        D_PS,
        D_PCL,
        D_PCH
    } dest_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PUSH_WR,
        S_PUSH_HOLD,
        S_PRE_INC,
        S_READ,
        S_PAD,
        S_FINISH
    } state_e;

    // Where the idx-th pulled byte of an instruction goes.
    function automatic dest_e dest_of(kind_e k, logic [CNT_W-1:0] idx);
        dest_e d;
        unique case (k)
            K_PULL_PS: d = D_PS;
            K_RET_INT: d = (idx == 2'd0) ? D_PS : ((idx == 2'd1) ? D_PCL : D_PCH);
            K_RET_SUB: d = (idx == 2'd0) ? D_PCL : D_PCH;
            default:   d = D_ACC;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/stack_seq_decode.sv
module stack_seq_decode
    import stack_seq_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    output kind_e             kind,
    output logic              legal,
    output logic              is_push,
    output logic [CNT_W-1:0]  pulls
);

    always_comb begin
        unique case (opcode)
            OP_PUSH_A:  kind = K_PUSH_A;
            OP_PUSH_PS: kind = K_PUSH_PS;
            OP_PULL_A:  kind = K_PULL_A;
            OP_PULL_PS: kind = K_PULL_PS;
            OP_RET_INT: kind = K_RET_INT;
            OP_RET_SUB: kind = K_RET_SUB;
            default:    kind = K_NONE;
        endcase
    end

    always_comb begin
        legal   = (kind != K_NONE);
        is_push = (kind == K_PUSH_A) || (kind == K_PUSH_PS);
        unique case (kind)
            K_PULL_A, K_PULL_PS: pulls = 2'd1;
            K_RET_SUB:           pulls = 2'd2;
            K_RET_INT:           pulls = 2'd3;
            default:             pulls = 2'd0;
        endcase
    end

endmodule

// File: rtl/stack_seq_ptr.sv
module stack_seq_ptr
    import stack_seq_pkg::*;
#(
    parameter logic [BYTE_W-1:0] SP_RESET = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_up,
    input  logic              step_down,
    output logic [BYTE_W-1:0] sp
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp <= SP_RESET;
        end else if (step_up) begin
            sp <= sp + 1'b1;
        end else if (step_down) begin
            sp <= sp - 1'b1;
        end
    end

    AST_PTR_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up && step_down)); // R9

endmodule

// File: rtl/stack_seq_ctrl.sv
module stack_seq_ctrl
    import stack_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  kind_e            kind_in,
    input  logic             legal,
    input  logic             is_push,
    input  logic [CNT_W-1:0] pulls_in,
    output kind_e            kind_q,
    output logic             busy,
    output logic             done,
    output logic             sp_up,
    output logic             sp_down,
    output logic             wr_en,
    output logic             cap_en,
    output dest_e            cap_dest
);

    state_e           state, nxt;
    logic [CNT_W-1:0] total_q;
    logic [CNT_W-1:0] issued_q;
    logic [CNT_W-1:0] caught_q;
    logic             pend_q;
    logic             issue;
    logic             last_cap;

    // State register and per-instruction counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            kind_q   <= K_NONE;
            total_q  <= '0;
            issued_q <= '0;
            caught_q <= '0;
            pend_q   <= 1'b0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && start && legal) begin
                kind_q   <= kind_in;
                total_q  <= pulls_in;
                issued_q <= '0;
                caught_q <= '0;
                pend_q   <= 1'b0;
            end else if (state == S_READ) begin
                issued_q <= issued_q + CNT_W'(issue);
                caught_q <= caught_q + CNT_W'(cap_en);
                pend_q   <= issue;
            end
        end
    end

    // Next state and control outputs
    always_comb begin
        nxt      = state;
        sp_up    = 1'b0;
        sp_down  = 1'b0;
        wr_en    = 1'b0;
        done     = 1'b0;
        issue    = 1'b0;
        cap_en   = 1'b0;
        last_cap = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (start && legal) begin
                    nxt = is_push ? S_PUSH_WR : S_PRE_INC;
                end
            end
            S_PUSH_WR: begin
                wr_en   = 1'b1;
                sp_down = 1'b1;
                nxt     = S_PUSH_HOLD;
            end
            S_PUSH_HOLD: begin
                nxt = S_FINISH;
            end
            S_PRE_INC: begin
                sp_up = 1'b1;
                nxt   = S_READ;
            end
            S_READ: begin
                issue    = (issued_q < total_q);
                sp_up    = issue && ((issued_q + 2'd1) < total_q);
                cap_en   = pend_q;
                last_cap = pend_q && ((caught_q + 2'd1) == total_q);
                if (last_cap) begin
                    nxt = (kind_q == K_RET_SUB) ? S_PAD : S_FINISH;
                end
            end
            S_PAD: begin
                nxt = S_FINISH;
            end
            S_FINISH: begin
                done = 1'b1;
                nxt  = S_IDLE;
            end
            default: nxt = S_IDLE;
        endcase
    end

    assign busy     = (state != S_IDLE);
    assign cap_dest = dest_of(kind_q, caught_q);

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R11
    AST_READ_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && cap_dest == D_PCL && kind_q == K_RET_INT) |-> $past(cap_en)); // R7
    AST_PRE_INC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PRE_INC) |=> (state == S_READ && !cap_en)); // R5

endmodule

// File: rtl/stack_seq.sv
module stack_seq
    import stack_seq_pkg::*;
#(
    parameter logic [7:0] STACK_PAGE = 8'h01,
    parameter logic [7:0] SP_RESET   = 8'hFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [7:0]  opcode,
    input  logic [7:0]  acc_in,
    input  logic [7:0]  ps_in,
    input  logic [7:0]  mem_rdata,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        mem_we,
    output logic [7:0]  acc_out,
    output logic        acc_we,
    output logic [7:0]  ps_out,
    output logic        ps_we,
    output logic [15:0] pc_out,
    output logic        pc_we,
    output logic [7:0]  sp,
    output logic        busy,
    output logic        done
);

    kind_e            dec_kind;
    kind_e            run_kind;
    logic             dec_legal;
    logic             dec_push;
    logic [CNT_W-1:0] dec_pulls;
    logic             sp_up;
    logic             sp_down;
    logic             cap_en;
    dest_e            cap_dest;
    logic [BYTE_W-1:0] pcl_q;

    stack_seq_decode u_decode (
        .opcode  (opcode),
        .kind    (dec_kind),
        .legal   (dec_legal),
        .is_push (dec_push),
        .pulls   (dec_pulls)
    );

    stack_seq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .kind_in  (dec_kind),
        .legal    (dec_legal),
        .is_push  (dec_push),
        .pulls_in (dec_pulls),
        .kind_q   (run_kind),
        .busy     (busy),
        .done     (done),
        .sp_up    (sp_up),
        .sp_down  (sp_down),
        .wr_en    (mem_we),
        .cap_en   (cap_en),
        .cap_dest (cap_dest)
    );

    stack_seq_ptr #(
        .SP_RESET (SP_RESET)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_up   (sp_up),
        .step_down (sp_down),
        .sp        (sp)
    );

    // Low PC byte is held until the high byte returns
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcl_q <= '0;
        end else if (cap_en && cap_dest == D_PCL) begin
            pcl_q <= mem_rdata;
        end
    end

    always_comb begin
        mem_addr  = {STACK_PAGE, sp};
        mem_wdata = (run_kind == K_PUSH_PS) ? ps_in : acc_in;
        acc_out   = mem_rdata;
        ps_out    = mem_rdata;
        acc_we    = cap_en && (cap_dest == D_ACC);
        ps_we     = cap_en && (cap_dest == D_PS);
        pc_we     = cap_en && (cap_dest == D_PCH);
        pc_out    = {mem_rdata, pcl_q} + ((run_kind == K_RET_SUB) ? 16'd1 : 16'd0);
    end

    AST_PUSH_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (!mem_we && !done) ##1 done); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, acc_we, ps_we, pc_we})); // R10
    AST_ACC_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we |=> done); // R5
    AST_RTI_PC_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && run_kind == K_RET_INT) |=> done); // R7
    AST_START_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R12

endmodule

// File: tb/stack_seq_test.sv
module stack_seq_test;

    localparam int         CLK_PERIOD = 10;
    localparam logic [7:0] PAGE       = 8'h3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [7:0]  acc_reg = 8'h00;
    logic [7:0]  ps_reg = 8'h00;
    logic [15:0] pc_reg = 16'h0000;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  acc_out;
    logic        acc_we;
    logic [7:0]  ps_out;
    logic        ps_we;
    logic [15:0] pc_out;
    logic        pc_we;
    logic [7:0]  sp;
    logic        busy;
    logic        done;

    logic [7:0]  mem [256];
    logic [7:0]  slot_val [256];
    logic [15:0] last_waddr = 16'h0;
    int          writes = 0;
    int          page_bad = 0;
    int          n_chk = 0;
    int          n_err = 0;
    bit          reported = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stack_seq #(.STACK_PAGE(PAGE)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .opcode    (opcode),
        .acc_in    (acc_reg),
        .ps_in     (ps_reg),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .acc_out   (acc_out),
        .acc_we    (acc_we),
        .ps_out    (ps_out),
        .ps_we     (ps_we),
        .pc_out    (pc_out),
        .pc_we     (pc_we),
        .sp        (sp),
        .busy      (busy),
        .done      (done)
    );

    // Memory with one cycle of read latency, plus the datapath registers
    always @(posedge clk) begin
        mem_rdata <= mem[mem_addr[7:0]];
        if (busy && mem_addr != {PAGE, sp}) page_bad <= page_bad + 1;
        if (mem_we) begin
            mem[mem_addr[7:0]] <= mem_wdata;
            last_waddr <= mem_addr;
            writes <= writes + 1;
        end
        if (acc_we) acc_reg <= acc_out;
        if (ps_we)  ps_reg  <= ps_out;
        if (pc_we)  pc_reg  <= pc_out;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        end
        $finish;
    endtask

    // Run one instruction; optionally pulse start again in cycle 2 (R11)
    task automatic run(input logic [7:0] op, input int exp_cyc, input string req, input bit poke);
        int got   = 0;
        int extra = 0;
        int bsy   = 0;
        @(negedge clk);
        start  = 1'b1;
        opcode = op;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            start  = poke && (k == 1);
            opcode = (poke && k == 1) ? 8'h48 : op;
            if (k <= exp_cyc && busy) bsy++;
            if (done) begin
                if (got == 0) got = k;
                else extra++;
            end
        end
        chk(got == exp_cyc, req, got, exp_cyc);
        chk(extra == 0 && bsy == exp_cyc && !busy, "R10", bsy, exp_cyc);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog R10 actual=hung expected=finished");
        report();
    end

    initial begin
        logic [7:0] spm;
        int         w0;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(sp == 8'hFF && !busy && !done && !mem_we && !acc_we && !ps_we && !pc_we,
            "R1", sp, 8'hFF);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sp == 8'hFF && !busy && !done, "R1", sp, 8'hFF);
        spm = 8'hFF;

        // Push sweep over every pointer value (R3, R2, R9)
        for (int k = 0; k < 256; k++) begin
            acc_reg = 8'((k * 37) + 5);
            slot_val[spm] = acc_reg;
            run(8'h48, 3, "R3", 1'b0);
            chk(mem[spm] == slot_val[spm], "R3", mem[spm], slot_val[spm]);
            chk(last_waddr == {PAGE, spm}, "R2", last_waddr, {PAGE, spm});
            spm = spm - 8'd1;
            chk(sp == spm, "R9", sp, spm);
        end

        // Pull sweep, reverse order (R5, R9)
        for (int k = 0; k < 256; k++) begin
            acc_reg = 8'h00;
            run(8'h68, 4, "R5", 1'b0);
            spm = spm + 8'd1;
            chk(acc_reg == slot_val[spm], "R5", acc_reg, slot_val[spm]);
            chk(sp == spm, "R9", sp, spm);
        end

        // Status push and pull (R4, R6)
        for (int v = 0; v < 8; v++) begin
            ps_reg  = 8'((v * 53) ^ 8'hA5);
            acc_reg = 8'h77;
            run(8'h08, 3, "R4", 1'b0);
            chk(mem[spm] == ps_reg, "R4", mem[spm], ps_reg);
            ps_reg = 8'h00;
            run(8'h28, 4, "R6", 1'b0);
            chk(ps_reg == 8'((v * 53) ^ 8'hA5), "R6", ps_reg, 8'((v * 53) ^ 8'hA5));
            chk(acc_reg == 8'h77 && sp == spm, "R6", sp, spm);
        end

        // Returns from shifted pointer positions, crossing the wrap
        for (int t = 0; t < 6; t++) begin
            run(8'h68, 4, "R5", 1'b0);
            spm = spm + 8'd1;
            acc_reg = 8'h12 + 8'(t); run(8'h48, 3, "R3", 1'b0);
            acc_reg = 8'hFF - 8'(t); run(8'h48, 3, "R3", 1'b0);
            acc_reg = 8'hC3 ^ 8'(t); run(8'h48, 3, "R3", 1'b0);
            spm = spm - 8'd3;
            ps_reg = 8'h00;
            run(8'h40, 6, "R7", 1'b0);
            spm = spm + 8'd3;
            chk(ps_reg == (8'hC3 ^ 8'(t)), "R7", ps_reg, 8'hC3 ^ 8'(t));
            chk(pc_reg == {8'h12 + 8'(t), 8'hFF - 8'(t)}, "R7", pc_reg,
                {8'h12 + 8'(t), 8'hFF - 8'(t)});
            chk(sp == spm, "R7", sp, spm);

            acc_reg = 8'h40 + 8'(t); run(8'h48, 3, "R3", 1'b0);
            acc_reg = 8'hFF - 8'(t); run(8'h48, 3, "R3", 1'b0);
            spm = spm - 8'd2;
            run(8'h60, 6, "R8", 1'b0);
            spm = spm + 8'd2;
            chk(pc_reg == ({8'h40 + 8'(t), 8'hFF - 8'(t)} + 16'd1), "R8", pc_reg,
                {8'h40 + 8'(t), 8'hFF - 8'(t)} + 16'd1);
            chk(sp == spm, "R8", sp, spm);
        end

        // Start during a busy pull (R11)
        mem[8'(spm + 8'd1)] = 8'h5A;
        w0 = writes;
        run(8'h68, 4, "R11", 1'b1);
        spm = spm + 8'd1;
        chk(writes == w0, "R11", writes, w0);
        chk(sp == spm && acc_reg == 8'h5A, "R11", sp, spm);

        // Opcodes outside the set (R12)
        for (int o = 0; o < 4; o++) begin
            logic [7:0] bad;
            int         seen;
            bad  = (o == 0) ? 8'hEA : (o == 1) ? 8'h00 : (o == 2) ? 8'h49 : 8'h61;
            seen = 0;
            @(negedge clk);
            start  = 1'b1;
            opcode = bad;
            @(negedge clk);
            start = 1'b0;
            for (int k = 0; k < 7; k++) begin
                if (busy || done || mem_we) seen++;
                @(negedge clk);
            end
            chk(seen == 0 && sp == spm, "R12", seen, 0);
        end

        chk(page_bad == 0, "R2", page_bad, 0);
        report();
    end

endmodule